// File: doc/BRIEF.md
# Configurable GPIO Port Data Path

This block is the per-pin data path of a general-purpose I/O port. It receives the configuration vectors held elsewhere (pin direction, output data, input inversion, driver float and pull-up enable) together with the raw pin levels. From these it produces the pin drive values, the driver enables, the pull-up enables and a readback word that reports the state of every pin. Bit n of every vector belongs to pin n.

Raw pin levels pass through a synchronizer whose depth is a parameter before they reach the readback path. For a pin configured as an input, the readback bit is the synchronized level, inverted when that pin's inversion bit is set. For a pin configured as an output, the readback bit is the stored output value, whatever the pin itself shows. An output pin can have its driver floated without changing its direction. The register storage, the serial access path and interrupt detection are not part of this block.

Top module: `gpio_port_path`

## Requirements
- R1: `cfg_dir` bit = 1 makes the pin an input and 0 makes it an output. For an input pin, `pin_oe` is 0 whatever `cfg_float` holds.
- R2: For an output pin, `pin_oe` is the inverse of that pin's `cfg_float` bit. A float bit of 1 switches the driver off.
- R3: `pin_out` equals `cfg_out` bit for bit, for every pin, in the same cycle.
- R4: For an input pin, the readback bit is the pin level sampled SYNC_STAGES (default 2) clock edges earlier, XOR that pin's `cfg_inv` bit.
- R5: For an output pin, the readback bit equals `cfg_out` for that pin in the same cycle. It ignores the pin level and `cfg_inv`.
- R6: `pin_pu` bit is 1 only when both `cfg_pu` and `cfg_dir` are 1 for that pin.
- R7: While `rst_n` is low, the synchronizer stages hold 0. The readback of an input pin therefore shows `cfg_inv` until fresh samples arrive.
- R8: The register-side reset values are exposed as the parameters RST_DIR (all ones, all pins inputs), RST_OUT (all ones) and RST_PU (all zeros).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir | input | WIDTH | Direction per pin, 1 = input |
| cfg_out | input | WIDTH | Output data per pin |
| cfg_inv | input | WIDTH | Input inversion per pin |
| cfg_float | input | WIDTH | Driver float per pin, 1 = driver off |
| cfg_pu | input | WIDTH | Pull-up request per pin |
| pin_in | input | WIDTH | Raw pin levels |
| pin_out | output | WIDTH | Pin drive values |
| pin_oe | output | WIDTH | Pin driver enables |
| pin_pu | output | WIDTH | Pull-up enables |
| rdback | output | WIDTH | Pin-state readback word |

## Verification
The hardest case to reach from the ports is a pin whose direction changes while its level is also changing. Just after such a change, the readback of an input pin still reflects samples taken while the pin was an output, so the synchronizer latency becomes visible. The stimulus randomizes direction, inversion and pin levels together on every cycle. The bench keeps its own delay line of pin levels, so every readback bit has a known expected value even across direction flips. Directed steps cover reset, all pins as inputs, all pins as outputs, and floated outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned GPIO_MAX_WIDTH = 64;
   localparam int unsigned GPIO_MAX_SYNC  = 4;
   typedef enum logic {DIR_OUT = 1'b0, DIR_IN = 1'b1} pin_dir_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2 || STAGES > gpio_port_pkg::GPIO_MAX_SYNC)
         $error("gpio_in_sync: STAGES out of range");
   end

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
   input  logic dir_in,
   input  logic out_val,
   input  logic inv,
   input  logic flt,
   input  logic pu_req,
   input  logic lvl_sync,
   output logic drv,
   output logic oe,
   output logic pu,
   output logic rb
);
   import gpio_port_pkg::*;
   pin_dir_e mode;
   assign mode = pin_dir_e'(dir_in);

   always_comb begin
      drv = out_val;
      oe  = 1'b0;
      pu  = 1'b0;
      rb  = out_val;
      unique case (mode)
         DIR_IN: begin
            pu = pu_req;
            rb = lvl_sync ^ inv;
         end
         DIR_OUT: begin
            oe = ~flt;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/gpio_port_path.sv
module gpio_port_path #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] RST_DIR = '1,
   parameter logic [WIDTH-1:0] RST_OUT = '1,
   parameter logic [WIDTH-1:0] RST_PU  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cfg_dir,
   input  logic [WIDTH-1:0] cfg_out,
   input  logic [WIDTH-1:0] cfg_inv,
   input  logic [WIDTH-1:0] cfg_float,
   input  logic [WIDTH-1:0] cfg_pu,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_pu,
   output logic [WIDTH-1:0] rdback
);
   localparam int unsigned LAST_PIN = WIDTH - 1;

   initial begin
      if (WIDTH < 1 || WIDTH > gpio_port_pkg::GPIO_MAX_WIDTH)
         $error("gpio_port_path: WIDTH out of range");
      if (RST_DIR != {WIDTH{1'b1}})
         $error("gpio_port_path: RST_DIR must leave all pins as inputs");
   end

   logic [WIDTH-1:0] lvl_sync;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
   );

   genvar i;
   generate
      for (i = 0; i <= LAST_PIN; i++) begin : g_pin
         gpio_pin_slice u_slice (
            .dir_in  (cfg_dir[i]),
            .out_val (cfg_out[i]),
            .inv     (cfg_inv[i]),
            .flt     (cfg_float[i]),
            .pu_req  (cfg_pu[i]),
            .lvl_sync(lvl_sync[i]),
            .drv     (pin_out[i]),
            .oe      (pin_oe[i]),
            .pu      (pin_pu[i]),
            .rb      (rdback[i])
         );
      end
   endgenerate
endmodule

// File: rtl/gpio_port_path_chk.sv
module gpio_port_path_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] cfg_dir,
   input logic [WIDTH-1:0] cfg_out,
   input logic [WIDTH-1:0] cfg_inv,
   input logic [WIDTH-1:0] cfg_float,
   input logic [WIDTH-1:0] cfg_pu,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_pu,
   input logic [WIDTH-1:0] rdback
);
   // R1
   input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & cfg_dir) == '0);
   // R2
   out_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~cfg_dir) == (~cfg_float & ~cfg_dir));
   // R3
   drive_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out == cfg_out);
   // R5
   out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdback & ~cfg_dir) == (cfg_out & ~cfg_dir));
   // R6
   pullup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & ~(cfg_pu & cfg_dir)) == '0);
   // R7
   reset_readback_chk: assert property (@(posedge clk)
      !rst_n |-> ((rdback & cfg_dir) == (cfg_inv & cfg_dir)));
endmodule

bind gpio_port_path gpio_port_path_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_out(cfg_out),
   .cfg_inv(cfg_inv), .cfg_float(cfg_float), .cfg_pu(cfg_pu),
   .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .rdback(rdback)
);

// File: tb/tb_gpio_port_path.sv
module tb_gpio_port_path;
   localparam int W = 8;
   logic clk = 0, rst_n = 0;
   logic [W-1:0] dir, outv, inv, flt, pu, pin;
   logic [W-1:0] p_out, p_oe, p_pu, rb;
   logic [W-1:0] h1 = '0, h2 = '0;   // bench delay line of pin levels
   int checks = 0, fails = 0;
   bit done = 0;

   gpio_port_path dut (
      .clk(clk), .rst_n(rst_n), .cfg_dir(dir), .cfg_out(outv), .cfg_inv(inv),
      .cfg_float(flt), .cfg_pu(pu), .pin_in(pin),
      .pin_out(p_out), .pin_oe(p_oe), .pin_pu(p_pu), .rdback(rb)
   );

   always #10 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) begin h1 <= '0; h2 <= '0; end
      else begin h1 <= pin; h2 <= h1; end

   function automatic logic [W-1:0] exp_rb(input logic [W-1:0] d, o, iv, s);
      return (d & (s ^ iv)) | (~d & o);
   endfunction

   task automatic chk(input string r, input logic [W-1:0] act, exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R1", p_oe & dir, '0);
      chk("R2", p_oe & ~dir, ~flt & ~dir);
      chk("R3", p_out, outv);
      chk("R4 R5", rb, exp_rb(dir, outv, inv, h2));
      chk("R6", p_pu, pu & dir);
   endtask

   task automatic step();
      @(posedge clk); #5;
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      // R8 reset values applied by register side
      dir = dut.RST_DIR; outv = dut.RST_OUT; pu = dut.RST_PU;
      inv = 8'h0F; flt = '0; pin = 8'hFF;
      #25;
      // R7 reset: synchronizer cleared, readback shows inversion
      chk("R7", rb, 8'h0F);
      chk("R8", p_pu, 8'h00);
      chk("R8", p_oe, 8'h00);
      rst_n = 1;
      step(); check_all();
      step(); check_all();
      // R4 after two edges, pin levels visible
      chk("R4", rb, 8'hF0);
      // directed: all outputs, floated half
      dir = 8'h00; outv = 8'hA5; flt = 8'hF0; pin = 8'h3C;
      #1; check_all();
      chk("R2", p_oe, 8'h0F);
      chk("R5", rb, 8'hA5);
      // R1 input pins ignore float
      dir = 8'hFF; flt = 8'hFF; #1;
      chk("R1", p_oe, 8'h00);
      // R4 latency: change pin, stays old for one edge
      inv = '0; step(); step();
      chk("R4", rb, 8'h3C);
      pin = 8'hC3; step();
      chk("R4", rb, 8'h3C);
      step();
      chk("R4", rb, 8'hC3);
      // random phase
      for (int k = 0; k < 3000; k++) begin
         dir = $urandom; outv = $urandom; inv = $urandom;
         flt = $urandom; pu = $urandom; pin = $urandom;
         #1; check_all();
         step(); check_all();
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule